// File: doc/BRIEF.md
# Integer to Floating-Point Converter

This unit turns a 64-bit integer operand into an IEEE 754 value held in a 64-bit register image. The operand is read as a signed or unsigned number, either 32 bits or 64 bits wide. The target precision is binary64 or binary32. A binary32 result is stored in its exact binary64 form, with the same value, the exponent re-biased and the fraction padded with zeros.

Each request is marked by a one-cycle valid strobe. The result and the status outputs are registered and appear one cycle later. Status is kept between conversions. It holds the class code, the rounded-up flag, the inexact flag, a sticky inexact bit and a summary bit.

A 32-bit integer converted to double precision is always exact. That conversion takes a path that writes only the result and leaves every status output as it was. Every other combination goes through rounding under the selected mode.

Top module: `i2f_convert`

## Requirements
- R1: `itype_i` selects the operand type: 0 is signed 32-bit, 1 is unsigned 32-bit, 2 is signed 64-bit and 3 is unsigned 64-bit. For the two 32-bit types, operand bits 63..32 have no effect on the result.
- R2: When `itype_i[1]` is 0 and `single_i` is 0, the result is the exact binary64 value. `class_o`, `rnd_up_o`, `inexact_o`, `sticky_inexact_o` and `summary_o` keep their previous values.
- R3: On every other path the value is rounded to binary64, or to binary32 when `single_i` is 1, using `rmode_i`. The encodings are 00 nearest-even, 01 toward zero, 10 toward +infinity and 11 toward -infinity.
- R4: A binary32 result is given as its exact binary64 equivalent, so result bits 28..0 are zero.
- R5: On the rounding path, `rnd_up_o` is 1 when rounding increased the magnitude, and `inexact_o` is 1 when the result differs from the operand. `rnd_up_o` implies `inexact_o`.
- R6: `sticky_inexact_o` is set by any inexact rounding-path conversion and is cleared only by reset.
- R7: `summary_o` is set in the same cycle that `sticky_inexact_o` changes from 0 to 1, and is cleared only by reset.
- R8: On the rounding path, `class_o` is 00010 for +zero, 00100 for a positive normal and 01000 for a negative normal.
- R9: An integer zero converts to +0. A negative signed operand gives the sign bit set and the converted magnitude.
- R10: Outputs change only on the clock edge at which `valid_i` is 1, and hold otherwise. After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Conversion request strobe |
| operand_i | input | 64 | Integer operand |
| itype_i | input | 2 | Integer type code |
| single_i | input | 1 | 1 selects a binary32 target |
| rmode_i | input | 2 | Rounding mode |
| result_o | output | 64 | Converted value in binary64 register format |
| class_o | output | 5 | Result class code |
| rnd_up_o | output | 1 | Magnitude was incremented by rounding |
| inexact_o | output | 1 | Last rounding-path result was inexact |
| sticky_inexact_o | output | 1 | Sticky inexact status |
| summary_o | output | 1 | Summary exception bit |

## Verification
The assertions check several rules on every cycle. Sticky and summary never clear. Summary rises together with sticky. Rounded-up always implies inexact. Any request on the exact path leaves class and flags unchanged. A single-precision request leaves the padded low fraction bits at zero. The bench scenarios cover what a property cannot show without a reference model. These are the actual encoded values under each rounding mode, including ties, carry out of the mantissa and negative operands in directed rounding. They also show that the upper operand bits are ignored for 32-bit types and that outputs hold when no request is made.

// File: rtl/i2f_pkg.sv
package i2f_pkg;
  localparam int DATA_W   = 64;
  localparam int DP_MANT  = 53;
  localparam int SP_MANT  = 24;
  localparam int DP_EXP_W = 11;
  localparam int DP_BIAS  = 1023;
  localparam int LZ_W     = $clog2(DATA_W) + 1;

  typedef enum logic [1:0] {
    RM_NEAR_EVEN = 2'b00,
    RM_ZERO      = 2'b01,
    RM_POS_INF   = 2'b10,
    RM_NEG_INF   = 2'b11
  } rmode_e;

  localparam logic [4:0] CLS_POS_ZERO = 5'b00010;
  localparam logic [4:0] CLS_POS_NORM = 5'b00100;
  localparam logic [4:0] CLS_NEG_NORM = 5'b01000;
endpackage

// File: rtl/i2f_operand.sv
module i2f_operand
  import i2f_pkg::*;
(
  input  logic [DATA_W-1:0] operand_i,
  input  logic [1:0]        itype_i,
  output logic              sign_o,
  output logic [DATA_W-1:0] mag_o
);
  localparam int HALF_W = DATA_W / 2;
  logic [DATA_W-1:0] ext;
  logic              is_signed;

  always_comb begin
    is_signed = ~itype_i[0];
    if (itype_i[1]) ext = operand_i;
    else if (is_signed) ext = {{HALF_W{operand_i[HALF_W-1]}}, operand_i[HALF_W-1:0]};
    else ext = {{HALF_W{1'b0}}, operand_i[HALF_W-1:0]};
    sign_o = is_signed & ext[DATA_W-1];
    mag_o  = sign_o ? (~ext + 1'b1) : ext;
  end
endmodule

// File: rtl/i2f_normalize.sv
module i2f_normalize
  import i2f_pkg::*;
(
  input  logic [DATA_W-1:0] mag_i,
  output logic [LZ_W-1:0]   lz_o,
  output logic [DATA_W-1:0] norm_o,
  output logic              zero_o
);
  always_comb begin
    lz_o = LZ_W'(DATA_W);
    for (int i = 0; i < DATA_W; i++)
      if (mag_i[i]) lz_o = LZ_W'(DATA_W - 1 - i);
    zero_o = (mag_i == '0);
    norm_o = zero_o ? '0 : (mag_i << lz_o);
  end
endmodule

// File: rtl/i2f_round.sv
module i2f_round
  import i2f_pkg::*;
#(
  parameter int MANT_W = DP_MANT
) (
  input  logic [DATA_W-1:0] norm_i,
  input  logic              sign_i,
  input  logic [1:0]        rmode_i,
  output logic [MANT_W-2:0] frac_o,
  output logic              carry_o,
  output logic              up_o,
  output logic              inexact_o
);
  localparam int TAIL_W = DATA_W - MANT_W;
  logic [MANT_W-1:0] mant;
  logic [TAIL_W-1:0] tail;
  logic              guard, sticky;
  logic [MANT_W:0]   sum;

  always_comb begin
    mant      = norm_i[DATA_W-1 -: MANT_W];
    tail      = norm_i[TAIL_W-1:0];
    guard     = tail[TAIL_W-1];
    sticky    = |(tail << 1);
    inexact_o = guard | sticky;
    unique case (rmode_e'(rmode_i))
      RM_NEAR_EVEN: up_o = guard & (sticky | mant[0]);
      RM_ZERO:      up_o = 1'b0;
      RM_POS_INF:   up_o = inexact_o & ~sign_i;
      RM_NEG_INF:   up_o = inexact_o & sign_i;
      default:      up_o = 1'b0;
    endcase
    sum     = {1'b0, mant} + (MANT_W+1)'(up_o);
    carry_o = sum[MANT_W];
    // on carry the mantissa wraps to 1.000..., so the fraction is zero
    frac_o  = carry_o ? '0 : sum[MANT_W-2:0];
  end
endmodule

// File: rtl/i2f_convert.sv
module i2f_convert
  import i2f_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [63:0]       operand_i,
  input  logic [1:0]        itype_i,
  input  logic              single_i,
  input  logic [1:0]        rmode_i,
  output logic [63:0]       result_o,
  output logic [4:0]        class_o,
  output logic              rnd_up_o,
  output logic              inexact_o,
  output logic              sticky_inexact_o,
  output logic              summary_o
);
  localparam int PAD_W   = DP_MANT - SP_MANT;
  localparam int EXP_TOP = DP_BIAS + DATA_W - 1;

  logic              sign, zero, exact_path;
  logic [DATA_W-1:0] mag, norm;
  logic [LZ_W-1:0]   lz;

  logic [DP_MANT-2:0] dp_frac;
  logic [SP_MANT-2:0] sp_frac;
  logic dp_carry, dp_up, dp_inx, sp_carry, sp_up, sp_inx;

  logic [DP_MANT-2:0]  frac_sel;
  logic                carry_sel, up_sel, inx_sel;
  logic [DP_EXP_W-1:0] exp_b;
  logic [DATA_W-1:0]   result_d;
  logic [4:0]          class_d;

  i2f_operand u_operand (.operand_i(operand_i), .itype_i(itype_i), .sign_o(sign), .mag_o(mag));
  i2f_normalize u_norm (.mag_i(mag), .lz_o(lz), .norm_o(norm), .zero_o(zero));

  i2f_round #(.MANT_W(DP_MANT)) u_round_dp (
    .norm_i(norm), .sign_i(sign), .rmode_i(rmode_i),
    .frac_o(dp_frac), .carry_o(dp_carry), .up_o(dp_up), .inexact_o(dp_inx));
  i2f_round #(.MANT_W(SP_MANT)) u_round_sp (
    .norm_i(norm), .sign_i(sign), .rmode_i(rmode_i),
    .frac_o(sp_frac), .carry_o(sp_carry), .up_o(sp_up), .inexact_o(sp_inx));

  always_comb begin
    exact_path = ~itype_i[1] & ~single_i;
    if (single_i) begin
      frac_sel  = {sp_frac, {PAD_W{1'b0}}};
      carry_sel = sp_carry;
      up_sel    = sp_up;
      inx_sel   = sp_inx;
    end else begin
      frac_sel  = dp_frac;
      carry_sel = dp_carry;
      up_sel    = dp_up;
      inx_sel   = dp_inx;
    end
    exp_b    = DP_EXP_W'(EXP_TOP) - DP_EXP_W'(lz) + DP_EXP_W'(carry_sel);
    result_d = zero ? '0 : {sign, exp_b, frac_sel};
    class_d  = zero ? CLS_POS_ZERO : (sign ? CLS_NEG_NORM : CLS_POS_NORM);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o         <= '0;
      class_o          <= '0;
      rnd_up_o         <= 1'b0;
      inexact_o        <= 1'b0;
      sticky_inexact_o <= 1'b0;
      summary_o        <= 1'b0;
    end else if (valid_i) begin
      result_o <= result_d;
      if (!exact_path) begin
        class_o          <= class_d;
        rnd_up_o         <= up_sel;
        inexact_o        <= inx_sel;
        sticky_inexact_o <= sticky_inexact_o | inx_sel;
        if (inx_sel && !sticky_inexact_o) summary_o <= 1'b1;
      end
    end
  end

  a_r2_exact_keeps_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !itype_i[1] && !single_i) |=>
      ($stable(class_o) && $stable(rnd_up_o) && $stable(inexact_o) &&
       $stable(sticky_inexact_o) && $stable(summary_o)));

  a_r4_single_padded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && single_i) |=> (result_o[PAD_W-1:0] == '0));

  a_r5_up_implies_inexact: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rnd_up_o |-> inexact_o);

  a_r6_sticky_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sticky_inexact_o |=> sticky_inexact_o);

  a_r7_summary_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sticky_inexact_o) |-> summary_o);

  a_r7_summary_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    summary_o |=> summary_o);

  a_r10_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(result_o) && $stable(class_o)));
endmodule

// File: tb/tb_i2f_convert.sv
module tb_i2f_convert;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [63:0] operand_i = '0;
  logic [1:0]  itype_i = '0;
  logic        single_i = 1'b0;
  logic [1:0]  rmode_i = '0;
  logic [63:0] result_o;
  logic [4:0]  class_o;
  logic        rnd_up_o, inexact_o, sticky_inexact_o, summary_o;

  int checks = 0;
  int errors = 0;

  localparam logic [4:0] C_PZERO = 5'b00010;
  localparam logic [4:0] C_PNORM = 5'b00100;
  localparam logic [4:0] C_NNORM = 5'b01000;

  always #2.5 clk_i = ~clk_i;

  i2f_convert dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // apply one request; sample after the registering edge
  task automatic convert(input logic [63:0] op, input logic [1:0] it,
                         input logic sgl, input logic [1:0] rm);
    @(negedge clk_i);
    operand_i = op; itype_i = it; single_i = sgl; rmode_i = rm; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  task automatic chk_flags(input string req, input logic [4:0] cls, input logic up,
                           input logic inx, input logic stk, input logic sum);
    chk({req, " class"}, 64'(class_o), 64'(cls));
    chk({req, " rnd_up"}, 64'(rnd_up_o), 64'(up));
    chk({req, " inexact"}, 64'(inexact_o), 64'(inx));
    chk({req, " sticky"}, 64'(sticky_inexact_o), 64'(stk));
    chk({req, " summary"}, 64'(summary_o), 64'(sum));
  endtask

  task automatic t_reset;
    chk("R10 reset result", result_o, 64'h0);
    chk_flags("R10 reset", 5'b0, 0, 0, 0, 0);
  endtask

  task automatic t_exact_32;
    convert(64'hFFFF_FFFF_FFFF_FFFF, 2'd0, 1'b0, 2'b00);
    chk("R2 R9 s32 -1", result_o, 64'hBFF0_0000_0000_0000);
    chk_flags("R2 exact", 5'b0, 0, 0, 0, 0);
    convert(64'hDEAD_BEEF_0000_0005, 2'd1, 1'b0, 2'b00);
    chk("R1 u32 ignores upper", result_o, 64'h4014_0000_0000_0000);
    convert(64'h0000_0000_8000_0000, 2'd0, 1'b0, 2'b00);
    chk("R1 s32 min", result_o, 64'hC1E0_0000_0000_0000);
  endtask

  task automatic t_zero;
    convert(64'h0, 2'd3, 1'b0, 2'b00);
    chk("R9 zero", result_o, 64'h0);
    chk_flags("R8 zero", C_PZERO, 0, 0, 0, 0);
  endtask

  task automatic t_modes_dp;
    convert(64'h0020_0000_0000_0001, 2'd3, 1'b0, 2'b00);
    chk("R3 tie even", result_o, 64'h4340_0000_0000_0000);
    chk_flags("R5 R6 R7 tie", C_PNORM, 0, 1, 1, 1);
    convert(64'h0020_0000_0000_0001, 2'd3, 1'b0, 2'b10);
    chk("R3 pos inf", result_o, 64'h4340_0000_0000_0001);
    chk_flags("R5 pos inf", C_PNORM, 1, 1, 1, 1);
    convert(64'h0020_0000_0000_0001, 2'd3, 1'b0, 2'b01);
    chk("R3 to zero", result_o, 64'h4340_0000_0000_0000);
    chk_flags("R5 to zero", C_PNORM, 0, 1, 1, 1);
    convert(-64'sd9007199254740993, 2'd2, 1'b0, 2'b11);
    chk("R3 R9 neg neg inf", result_o, 64'hC340_0000_0000_0001);
    chk_flags("R8 neg", C_NNORM, 1, 1, 1, 1);
    convert(-64'sd9007199254740993, 2'd2, 1'b0, 2'b10);
    chk("R3 neg pos inf", result_o, 64'hC340_0000_0000_0000);
    chk_flags("R5 neg pos inf", C_NNORM, 0, 1, 1, 1);
    convert(64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 1'b0, 2'b00);
    chk("R3 carry", result_o, 64'h43F0_0000_0000_0000);
    chk_flags("R5 carry", C_PNORM, 1, 1, 1, 1);
  endtask

  task automatic t_exact_after_inexact;
    convert(64'h0000_0000_FFFF_FFFF, 2'd0, 1'b0, 2'b00);
    chk("R2 keep result", result_o, 64'hBFF0_0000_0000_0000);
    chk_flags("R2 keep", C_PNORM, 1, 1, 1, 1);
    convert(-64'sd5, 2'd2, 1'b0, 2'b00);
    chk("R9 s64 -5", result_o, 64'hC014_0000_0000_0000);
    chk_flags("R6 exact rnd path", C_NNORM, 0, 0, 1, 1);
  endtask

  task automatic t_single;
    convert(64'h0000_0000_0100_0001, 2'd1, 1'b1, 2'b00);
    chk("R4 sp tie", result_o, 64'h4170_0000_0000_0000);
    chk_flags("R4 sp tie", C_PNORM, 0, 1, 1, 1);
    convert(64'h0000_0000_0100_0001, 2'd1, 1'b1, 2'b10);
    chk("R4 sp pos inf", result_o, 64'h4170_0000_2000_0000);
    chk_flags("R4 sp up", C_PNORM, 1, 1, 1, 1);
    convert(64'h3, 2'd1, 1'b1, 2'b00);
    chk("R4 sp exact 3", result_o, 64'h4008_0000_0000_0000);
    chk_flags("R4 sp exact", C_PNORM, 0, 0, 1, 1);
  endtask

  task automatic t_hold;
    @(negedge clk_i);
    operand_i = 64'h1234; itype_i = 2'd3; single_i = 1'b0; rmode_i = 2'b00;
    repeat (3) @(negedge clk_i);
    chk("R10 hold result", result_o, 64'h4008_0000_0000_0000);
    chk_flags("R10 hold", C_PNORM, 0, 0, 1, 1);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_exact_32();
    t_zero();
    t_modes_dp();
    t_exact_after_inexact();
    t_single();
    t_hold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule